// File: doc/BRIEF.md
# Smoothed FSK NCO Modulator

This block is a numerically controlled oscillator that turns a serial data bit into a binary FSK carrier. A 24-bit phase accumulator advances by one increment every system clock. In steady state the increment is a carrier word plus a deviation word for a mark (effective bit 1), or the carrier word minus the deviation word for a space (effective bit 0). At a 20 MHz system clock, a carrier word of 2103863 places the centre near 2.508 MHz. A deviation word of 27330 gives a shift of about 32.58 kHz.

A change of symbol does not make the increment jump. An internal level runs from 0 (full space) to 8 (full mark) and moves by one unit at each step boundary. Step boundaries fall every four clocks, so a full swing takes eight equal steps. This softens the spectral side lobes of the transmitted signal. A processor may rewrite the carrier word at any time for fine frequency correction. The new value is taken only at a step boundary, so a step never carries a mixed frequency. An inversion input flips the polarity of the data before it reaches the ramp.

The outputs are the top bits of the accumulator and a square wave taken from its most significant bit. A later stage can drive a DAC or a sine table from these.

Top module: `fsk_nco_mod`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator clears to 0, the level goes to 0 (space) and the held carrier becomes the CARRIER_RST parameter (2103863 by default). After reset the first increment is therefore CARRIER_RST minus `dev_word`.
- R2: Each clock out of reset, the 24-bit accumulator adds the increment of the previous cycle, modulo 2^24. `phase_out` shows the top OUT_W bits of the accumulator.
- R3: The increment is held carrier + floor((2·L − 8)·`dev_word` / 8), where L is the level. At L = 8 this is carrier + `dev_word` (mark). At L = 0 it is carrier − `dev_word` (space).
- R4: The level changes only at a step boundary, and then by exactly one unit toward the target. The target is 8 when the effective bit is 1 and 0 when it is 0. The level stays within 0..8, so a full swing makes 8 equal increment steps of 2·`dev_word`/8 each, and the slope never overshoots.
- R5: A step boundary occurs at every fourth rising edge after reset is released. The first boundary is at the fourth edge.
- R6: `carrier_word` is sampled only at a step boundary. A change made between boundaries leaves the increment unchanged until the next boundary edge.
- R7: The effective bit is `data_bit` XOR `invert_en`. Both inputs are sampled at the step boundary.
- R8: `sq_out` equals the most significant bit of the accumulator.
- R9: If the effective bit reverses during a ramp, the level turns back from its present value at the next boundary, with no jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| data_bit | input | 1 | Data bit to transmit |
| invert_en | input | 1 | 1 inverts the data polarity |
| carrier_word | input | 24 | Centre-frequency phase increment, programmable at run time |
| dev_word | input | 20 | Deviation increment added for mark, subtracted for space |
| phase_out | output | OUT_W (8) | Top bits of the phase accumulator |
| sq_out | output | 1 | Square-wave output, the accumulator MSB |

## Verification
A long steady space and a long steady mark each show a constant phase slope of carrier − dev and carrier + dev, which separates the two polarities. A single 0-to-1 change exposes the ramp: eight equal rises, spaced four clocks apart, with nothing out of order. The inverted-polarity runs, a reversal in mid-ramp and a carrier rewrite placed just after a boundary each isolate one control: polarity, turn-back from an intermediate level, and when the carrier is sampled. Random data, inversion, carrier and deviation then run against a cycle-level model of the accumulator to catch any disagreement in the wrap or the floor rounding.

// File: rtl/fsk_nco_pkg.sv
package fsk_nco_pkg;

    localparam int ACC_W      = 24;
    localparam int DEV_W      = 20;
    localparam int RAMP_STEPS = 8;
    localparam int RAMP_LOG   = $clog2(RAMP_STEPS);
    localparam int LVL_W      = $clog2(RAMP_STEPS + 1);
    localparam int OFF_W      = DEV_W + LVL_W + 2;

    typedef logic [ACC_W-1:0] phase_t;
    typedef logic [DEV_W-1:0] dev_t;
    typedef logic [LVL_W-1:0] level_t;

    // centre near 2.508 MHz and shift near 32.58 kHz at a 20 MHz clock
    localparam phase_t CARRIER_NOM = phase_t'(2103863);
    localparam dev_t   DEV_NOM     = dev_t'(27330);

    localparam level_t LVL_SPACE = '0;
    localparam level_t LVL_MARK  = level_t'(RAMP_STEPS);

    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_UP   = 2'd1,
        RAMP_DOWN = 2'd2
    } ramp_dir_e;

    typedef struct packed {
        level_t level;
        phase_t carrier;
    } tone_state_t;

    // choose the direction the level moves toward the target symbol
    function automatic ramp_dir_e dir_of(level_t lvl, logic sym);
        ramp_dir_e d;
        d = RAMP_HOLD;
        if (sym && (lvl != LVL_MARK))
            d = RAMP_UP;
        else if (!sym && (lvl != LVL_SPACE))
            d = RAMP_DOWN;
        return d;
    endfunction

    // floor((2*lvl - STEPS) * dev / STEPS), reduced modulo 2^ACC_W
    function automatic phase_t offset_of(level_t lvl, dev_t dev);
        logic signed [OFF_W-1:0] k;
        logic signed [OFF_W-1:0] p;
        k = $signed({{(OFF_W-LVL_W-1){1'b0}}, lvl, 1'b0}) - $signed(OFF_W'(RAMP_STEPS));
        p = k * $signed({{(OFF_W-DEV_W){1'b0}}, dev});
        p = p >>> RAMP_LOG;
        return p[ACC_W-1:0];
    endfunction

    function automatic phase_t incr_of(tone_state_t st, dev_t dev);
        return st.carrier + offset_of(st.level, dev);
    endfunction

endpackage

// File: rtl/fsk_step_timer.sv
module fsk_step_timer
#(
    parameter int STEP_CLKS = 4,
    localparam int TICK_W   = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1
)
(
    input  logic              clk,
    input  logic              rst,
    output logic [TICK_W-1:0] tick,
    output logic              boundary
);

    generate
        if (STEP_CLKS > 1) begin : g_count
            logic [TICK_W-1:0] tick_q;
            localparam logic [TICK_W-1:0] LAST = TICK_W'(STEP_CLKS - 1);

            always_ff @(posedge clk) begin
                if (rst || (tick_q == LAST))
                    tick_q <= '0;
                else
                    tick_q <= tick_q + 1'b1;
            end

            assign tick     = tick_q;
            assign boundary = (tick_q == LAST);
        end else begin : g_every
            assign tick     = '0;
            assign boundary = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/fsk_level_ramp.sv
module fsk_level_ramp
    import fsk_nco_pkg::*;
#(
    parameter phase_t CARRIER_RST = CARRIER_NOM
)
(
    input  logic        clk,
    input  logic        rst,
    input  logic        boundary,
    input  logic        data_bit,
    input  logic        invert_en,
    input  phase_t      carrier_word,
    output tone_state_t state
);

    tone_state_t st_q;
    ramp_dir_e   dir;
    logic        sym;

    assign sym = data_bit ^ invert_en;
    assign dir = dir_of(st_q.level, sym);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.level   <= LVL_SPACE;
            st_q.carrier <= CARRIER_RST;
        end else if (boundary) begin
            st_q.carrier <= carrier_word;
            case (dir)
                RAMP_UP:   st_q.level <= st_q.level + 1'b1;
                RAMP_DOWN: st_q.level <= st_q.level - 1'b1;
                default:   st_q.level <= st_q.level;
            endcase
        end
    end

    assign state = st_q;

endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc
    import fsk_nco_pkg::*;
#(
    parameter int OUT_W = 8
)
(
    input  logic             clk,
    input  logic             rst,
    input  tone_state_t      state,
    input  dev_t             dev_word,
    output phase_t           acc,
    output phase_t           incr,
    output logic [OUT_W-1:0] phase_out,
    output logic             sq_out
);

    phase_t acc_q;

    assign incr = incr_of(state, dev_word);

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else
            acc_q <= acc_q + incr;
    end

    assign acc       = acc_q;
    assign phase_out = acc_q[ACC_W-1 -: OUT_W];
    assign sq_out    = acc_q[ACC_W-1];

endmodule

// File: rtl/fsk_nco_mod.sv
module fsk_nco_mod
    import fsk_nco_pkg::*;
#(
    parameter int     OUT_W       = 8,
    parameter int     STEP_CLKS   = 4,
    parameter phase_t CARRIER_RST = CARRIER_NOM,
    localparam int    TICK_W      = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1
)
(
    input  logic             clk,
    input  logic             rst,
    input  logic             data_bit,
    input  logic             invert_en,
    input  logic [ACC_W-1:0] carrier_word,
    input  logic [DEV_W-1:0] dev_word,
    output logic [OUT_W-1:0] phase_out,
    output logic             sq_out
);

    logic [TICK_W-1:0] tick_w;
    logic              boundary_w;
    tone_state_t       state_w;
    phase_t            acc_w;
    phase_t            incr_w;
    level_t            level_w;
    phase_t            carrier_w;

    fsk_step_timer #(.STEP_CLKS(STEP_CLKS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_w),
        .boundary (boundary_w)
    );

    fsk_level_ramp #(.CARRIER_RST(CARRIER_RST)) u_ramp (
        .clk          (clk),
        .rst          (rst),
        .boundary     (boundary_w),
        .data_bit     (data_bit),
        .invert_en    (invert_en),
        .carrier_word (carrier_word),
        .state        (state_w)
    );

    fsk_phase_acc #(.OUT_W(OUT_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .state     (state_w),
        .dev_word  (dev_word),
        .acc       (acc_w),
        .incr      (incr_w),
        .phase_out (phase_out),
        .sq_out    (sq_out)
    );

    assign level_w   = state_w.level;
    assign carrier_w = state_w.carrier;

endmodule

// File: rtl/fsk_nco_checker.sv
module fsk_nco_checker
    import fsk_nco_pkg::*;
#(
    parameter int  STEP_CLKS = 4,
    localparam int TICK_W    = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1
)
(
    input logic              clk,
    input logic              rst,
    input logic [TICK_W-1:0] tick,
    input level_t            level,
    input phase_t            carrier_q,
    input dev_t              dev_word,
    input phase_t            incr,
    input phase_t            acc
);

    localparam logic [TICK_W-1:0] LAST = TICK_W'(STEP_CLKS - 1);

    assert_phase_adv_R2: assert property (@(posedge clk) disable iff (rst)
        (!rst) |=> (acc == $past(acc) + $past(incr)));

    assert_mark_incr_R3: assert property (@(posedge clk) disable iff (rst)
        (level == LVL_MARK) |-> (incr == carrier_q + phase_t'(dev_word)));

    assert_space_incr_R3: assert property (@(posedge clk) disable iff (rst)
        (level == LVL_SPACE) |-> (incr == carrier_q - phase_t'(dev_word)));

    assert_level_range_R4: assert property (@(posedge clk) disable iff (rst)
        int'(level) <= RAMP_STEPS);

    assert_level_unit_R4: assert property (@(posedge clk) disable iff (rst)
        (!rst) |=> (int'(level) == int'($past(level)) ||
                    int'(level) == int'($past(level)) + 1 ||
                    int'(level) + 1 == int'($past(level))));

    assert_level_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (tick != LAST) |=> $stable(level));

    assert_carrier_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (tick != LAST) |=> $stable(carrier_q));

endmodule

bind fsk_nco_mod fsk_nco_checker #(.STEP_CLKS(STEP_CLKS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_w),
    .level     (level_w),
    .carrier_q (carrier_w),
    .dev_word  (dev_word),
    .incr      (incr_w),
    .acc       (acc_w)
);

// File: tb/fsk_nco_mod_tb.sv
module fsk_nco_mod_tb;
    import fsk_nco_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             data_bit = 1'b0;
    logic             invert_en = 1'b0;
    logic [ACC_W-1:0] carrier_word = CARRIER_NOM;
    logic [DEV_W-1:0] dev_word = 20'd27328;
    logic [ACC_W-1:0] phase_out;
    logic             sq_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model state
    int      m_tick = 0;
    int      m_level = 0;
    phase_t  m_car = CARRIER_NOM;
    phase_t  m_acc = '0;
    phase_t  prev_phase = '0;
    phase_t  slope = '0;

    always #2 clk = ~clk;

    fsk_nco_mod #(.OUT_W(ACC_W)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .data_bit     (data_bit),
        .invert_en    (invert_en),
        .carrier_word (carrier_word),
        .dev_word     (dev_word),
        .phase_out    (phase_out),
        .sq_out       (sq_out)
    );

    function automatic phase_t exp_incr(phase_t car, int lvl, logic [DEV_W-1:0] dv);
        longint off;
        off = longint'(2 * lvl - 8) * longint'(dv);
        off = off >>> 3;
        return car + phase_t'(off);
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // advance one clock; the model follows the requirements
    task automatic cycle();
        logic r, d, iv;
        phase_t cw;
        logic [DEV_W-1:0] dv;
        r = rst; d = data_bit; iv = invert_en; cw = carrier_word; dv = dev_word;
        @(posedge clk);
        #1;
        if (r) begin
            m_tick = 0; m_level = 0; m_car = CARRIER_NOM; m_acc = '0;
        end else begin
            m_acc = m_acc + exp_incr(m_car, m_level, dv);
            if (m_tick == 3) begin
                if ((d ^ iv) && m_level < 8) m_level++;
                else if (!(d ^ iv) && m_level > 0) m_level--;
                m_car = cw;
            end
            m_tick = (m_tick + 1) % 4;
        end
        slope = phase_out - prev_phase;
        prev_phase = phase_out;
        check(phase_out == m_acc, "R2", "phase", phase_out, m_acc);
        check(sq_out == m_acc[ACC_W-1], "R8", "square", sq_out, m_acc[ACC_W-1]);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_up();
    end

    initial begin
        phase_t base;
        phase_t prev_s;
        int rises;
        int last_rise;
        bit mono;
        bit equal_steps;
        bit gap_ok;
        bit jump_ok;
        void'($urandom(32'd1234));

        // R1: reset state
        run(3);
        check(phase_out == 0, "R1", "reset phase", phase_out, 0);
        check(sq_out == 0, "R1", "reset square", sq_out, 0);
        rst = 1'b0;
        cycle();
        check(phase_out == CARRIER_NOM - 24'd27328, "R1", "first increment",
              phase_out, CARRIER_NOM - 24'd27328);

        // R3: steady space slope
        run(20);
        check(slope == CARRIER_NOM - 24'd27328, "R3", "space slope", slope, CARRIER_NOM - 24'd27328);

        // R4, R5: ramp from space to mark
        data_bit = 1'b1;
        rises = 0; last_rise = -1; mono = 1; equal_steps = 1; gap_ok = 1;
        prev_s = slope;
        for (int i = 0; i < 48; i++) begin
            cycle();
            if (slope != prev_s) begin
                if (slope < prev_s) mono = 0;
                if (slope - prev_s != 24'd6832) equal_steps = 0;
                if (last_rise >= 0 && i - last_rise != 4) gap_ok = 0;
                last_rise = i;
                rises++;
            end
            prev_s = slope;
        end
        check(mono, "R4", "monotonic ramp", mono, 1);
        check(rises == 8, "R4", "step count", rises, 8);
        check(equal_steps, "R4", "equal steps", equal_steps, 1);
        check(gap_ok, "R5", "step spacing", gap_ok, 1);
        check(slope == CARRIER_NOM + 24'd27328, "R3", "mark slope", slope, CARRIER_NOM + 24'd27328);

        // R7: inversion turns a 1 into space, and a 0 into mark
        invert_en = 1'b1;
        run(40);
        check(slope == CARRIER_NOM - 24'd27328, "R7", "inverted one", slope, CARRIER_NOM - 24'd27328);
        data_bit = 1'b0;
        run(40);
        check(slope == CARRIER_NOM + 24'd27328, "R7", "inverted zero", slope, CARRIER_NOM + 24'd27328);
        invert_en = 1'b0;

        // R9: reversal mid-ramp turns back without a jump
        run(40);
        jump_ok = 1;
        data_bit = 1'b1;
        prev_s = slope;
        for (int i = 0; i < 60; i++) begin
            if (i == 12) data_bit = 1'b0;
            cycle();
            if (slope - prev_s != 0 && slope - prev_s != 24'd6832 && prev_s - slope != 24'd6832)
                jump_ok = 0;
            prev_s = slope;
        end
        check(jump_ok, "R9", "reversal steps", jump_ok, 1);
        check(slope == CARRIER_NOM - 24'd27328, "R9", "reversal end", slope, CARRIER_NOM - 24'd27328);

        // R6: carrier change just after a boundary waits for the next one
        while (m_tick != 0) cycle();
        base = slope;
        carrier_word = CARRIER_NOM + 24'd1000;
        for (int i = 0; i < 4; i++) begin
            cycle();
            check(slope == base, "R6", "carrier held", slope, base);
        end
        cycle();
        check(slope == base + 24'd1000, "R6", "carrier applied", slope, base + 24'd1000);

        // R2, R3, R4, R7: random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 9) == 0) data_bit = ~data_bit;
            if ($urandom_range(0, 199) == 0) invert_en = ~invert_en;
            if ($urandom_range(0, 99) == 0) carrier_word = phase_t'($urandom);
            if ($urandom_range(0, 299) == 0) dev_word = DEV_W'($urandom_range(0, 524287));
            cycle();
        end

        finish_up();
    end

endmodule